// File: doc/BRIEF.md
# Minute-resolution masked calendar alarm

This unit watches a running calendar and raises an alarm when the programmed minute, hour, day-of-month and weekday agree with it. Each of the four alarm bytes carries a disable bit in its top position: a field whose top bit is 1 drops out of the comparison, and a field whose top bit is 0 must agree. The comparison is made once per minute, on the calendar step that brings the seconds count to BCD `00`. There is no seconds, month or year field.

A match sets a sticky alarm flag in the second control byte. Software clears the flag by writing 0 to its bit. The same byte also holds a flag that is set on every calendar step. An active-low, level-type interrupt line is asserted while the alarm flag and the alarm interrupt enable in the first control byte are both 1. All state is reached through one byte-wide register port: writes are taken on the clock edge, and reads are combinational from the address.

Top module: `alm_unit`

## Requirements
- R1: After reset the alarm bytes at 0x0A..0x0D read 0x80, the control bytes at 0x00 and 0x01 read 0x00, and `alarm_irq_n` is 1.
- R2: The alarm bytes are minute at 0x0A, hour at 0x0B, day-of-month at 0x0C and weekday at 0x0D, and each reads back the full byte written. Address 0x00 reads back only bit 1 (the alarm interrupt enable). Address 0x01 reads only bit 3 (alarm flag) and bit 4 (step flag). Every other bit and every unmapped address reads 0.
- R3: A comparison happens only on a cycle with `cal_step`=1 and `cal_sec`=0x00. When it matches, the alarm flag reads 1 from the following cycle. A step with any other seconds value never sets the flag.
- R4: A field with bit 7 = 0 takes part in the match. It compares its low bits with the calendar input through a field mask: 0x7F for minute, 0x3F for hour and day-of-month, 0x07 for weekday. A field with bit 7 = 1 is ignored whatever its value.
- R5: When all four fields have bit 7 = 1, no comparison sets the flag.
- R6: Writing 0x01 with bit 3 = 0 clears the alarm flag. Writing 1 to bit 3 leaves it unchanged. If a matching comparison falls in the same cycle as a clearing write, the flag ends up set.
- R7: `alarm_irq_n` is 0 exactly while the alarm flag and bit 1 of 0x00 are both 1. It holds that level for as long as both stay set.
- R8: Every `cal_step` sets bit 4 of 0x01. A write to 0x01 with bit 4 = 0 clears it unless a step falls in the same cycle. Writing 1 to bit 4 leaves it unchanged.
- R9: A comparison in which any enabled field differs from the calendar leaves the flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (5) | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cal_step | input | 1 | Calendar advanced by one second this cycle |
| cal_sec | input | 8 | Calendar seconds, BCD |
| cal_min | input | 8 | Calendar minutes, BCD |
| cal_hour | input | 8 | Calendar hours, BCD |
| cal_date | input | 8 | Calendar day of month, BCD |
| cal_wday | input | 8 | Calendar weekday |
| alarm_irq_n | output | 1 | Alarm interrupt, active low, level |

## Verification
The hardest case to reach is a matching comparison and a clearing write to 0x01 that land on the same clock edge. Only when both strobes share an edge does the design have to choose an order, and R6 makes the set win. The bench drives `reg_wr` and `cal_step` together in one cycle on purpose to reach this case. It also builds near-miss cases: a matching minute on a step whose seconds are not zero, a weekday mismatch hidden behind a disabled field, and an hour byte with a stray bit 6 that the field mask must discard.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ALM_DW   = 8;
  localparam int ALM_NF   = 4;
  localparam int EN_N_BIT = 7;
  localparam int IE_BIT   = 1;
  localparam int AF_BIT   = 3;
  localparam int SF_BIT   = 4;
  localparam logic [7:0] CTRL_A_ADDR = 8'h00;
  localparam logic [7:0] CTRL_B_ADDR = 8'h01;
  localparam logic [7:0] ALM_BASE    = 8'h0A;
  localparam logic [ALM_DW-1:0] ALM_RST = 8'h80;

  typedef logic [ALM_DW-1:0] alm_byte_t;

  // value bits that take part in the compare, per field (0=min .. 3=wday)
  function automatic alm_byte_t field_mask(input int idx);
    case (idx)
      0:       return 8'h7F;
      1, 2:    return 8'h3F;
      default: return 8'h07;
    endcase
  endfunction

  // a disabled field always agrees
  function automatic logic field_ok(input alm_byte_t alm, input alm_byte_t cal,
                                    input alm_byte_t msk);
    return alm[EN_N_BIT] | ((alm & msk) == (cal & msk));
  endfunction
endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
  import alm_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [AW-1:0]         reg_addr,
  input  alm_byte_t             reg_wdata,
  output alm_byte_t [ALM_NF-1:0] alm_q,
  output logic                  ie_q
);
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_A_ADDR);

  for (genvar g = 0; g < ALM_NF; g++) begin : g_field
    localparam logic [AW-1:0] A_FLD = AW'(ALM_BASE + 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          alm_q[g] <= ALM_RST;
      else if (reg_wr && reg_addr == A_FLD) alm_q[g] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ie_q <= 1'b0;
    else if (reg_wr && reg_addr == A_CTRL) ie_q <= reg_wdata[IE_BIT];
  end
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
(
  input  alm_byte_t [ALM_NF-1:0] alm_q,
  input  alm_byte_t [ALM_NF-1:0] cal_vec,
  input  logic                   cal_step,
  input  alm_byte_t              cal_sec,
  output logic                   eval_pulse,
  output logic                   any_en,
  output logic                   match_hit
);
  logic [ALM_NF-1:0] fld_ok;
  logic [ALM_NF-1:0] fld_en;

  for (genvar g = 0; g < ALM_NF; g++) begin : g_cmp
    assign fld_ok[g] = field_ok(alm_q[g], cal_vec[g], field_mask(g));
    assign fld_en[g] = ~alm_q[g][EN_N_BIT];
  end

  assign eval_pulse = cal_step && (cal_sec == '0);
  assign any_en     = |fld_en;
  assign match_hit  = any_en && (&fld_ok);
endmodule

// File: rtl/alm_status.sv
module alm_status
  import alm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctrl_b_wr,
  input  alm_byte_t reg_wdata,
  input  logic      eval_pulse,
  input  logic      match_hit,
  input  logic      cal_step,
  output logic      flag_q,
  output logic      step_q
);
  logic flag_set, flag_clr;
  assign flag_set = eval_pulse && match_hit;
  assign flag_clr = ctrl_b_wr && !reg_wdata[AF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      step_q <= 1'b0;
    end else begin
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (cal_step)                              step_q <= 1'b1;
      else if (ctrl_b_wr && !reg_wdata[SF_BIT])  step_q <= 1'b0;
    end
  end
endmodule

// File: rtl/alm_unit.sv
module alm_unit
  import alm_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          cal_step,
  input  logic [7:0]    cal_sec,
  input  logic [7:0]    cal_min,
  input  logic [7:0]    cal_hour,
  input  logic [7:0]    cal_date,
  input  logic [7:0]    cal_wday,
  output logic          alarm_irq_n
);
  localparam logic [AW-1:0] A_CTRL_A = AW'(CTRL_A_ADDR);
  localparam logic [AW-1:0] A_CTRL_B = AW'(CTRL_B_ADDR);

  alm_byte_t [ALM_NF-1:0] alm_q;
  alm_byte_t [ALM_NF-1:0] cal_vec;
  logic ie_q, flag_q, step_q;
  logic eval_pulse, any_en, match_hit, ctrl_b_wr;

  assign cal_vec   = {cal_wday, cal_date, cal_hour, cal_min};
  assign ctrl_b_wr = reg_wr && (reg_addr == A_CTRL_B);

  alm_regfile #(.AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .alm_q(alm_q), .ie_q(ie_q)
  );

  alm_match match_i (
    .alm_q(alm_q), .cal_vec(cal_vec), .cal_step(cal_step), .cal_sec(cal_sec),
    .eval_pulse(eval_pulse), .any_en(any_en), .match_hit(match_hit)
  );

  alm_status stat_i (
    .clk(clk), .rst_n(rst_n), .ctrl_b_wr(ctrl_b_wr), .reg_wdata(reg_wdata),
    .eval_pulse(eval_pulse), .match_hit(match_hit), .cal_step(cal_step),
    .flag_q(flag_q), .step_q(step_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL_A) begin
      reg_rdata[IE_BIT] = ie_q;
    end else if (reg_addr == A_CTRL_B) begin
      reg_rdata[AF_BIT] = flag_q;
      reg_rdata[SF_BIT] = step_q;
    end else begin
      for (int i = 0; i < ALM_NF; i++)
        if (reg_addr == AW'(ALM_BASE + 8'(i))) reg_rdata = alm_q[i];
    end
  end

  assign alarm_irq_n = ~(flag_q & ie_q);
endmodule

// File: rtl/alm_unit_chk.sv
module alm_unit_chk
  import alm_pkg::*;
#(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          eval_pulse,
  input logic          match_hit,
  input logic          any_en,
  input logic          flag_q,
  input logic          ie_q,
  input logic          alarm_irq_n
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_addr == AW'(CTRL_B_ADDR)) && !reg_wdata[AF_BIT];

  a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_pulse && match_hit) |=> flag_q);

  a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !(eval_pulse && match_hit)) |=> !flag_q);

  a_r5_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_en && !flag_q) |=> !flag_q);

  a_r6_clear_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(eval_pulse && match_hit)) |=> !flag_q);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_wr) |=> flag_q);

  a_r7_irq_active: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && ie_q) |-> !alarm_irq_n);

  a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q || !ie_q) |-> alarm_irq_n);
endmodule

bind alm_unit alm_unit_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .eval_pulse(eval_pulse), .match_hit(match_hit),
  .any_en(any_en), .flag_q(flag_q), .ie_q(ie_q), .alarm_irq_n(alarm_irq_n)
);

// File: tb/alm_unit_tb_top.sv
module alm_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cal_step = 1'b0;
  logic [7:0] cal_sec = 8'h01, cal_min = '0, cal_hour = '0, cal_date = 8'h01, cal_wday = '0;
  logic       alarm_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alm_unit dut_i (.*);

  // behavioural reference model
  int m_alm[4];
  bit m_ie, m_flag, m_sf;

  function automatic bit m_hit();
    int lim[4] = '{127, 63, 63, 7};
    int en = 0;
    for (int i = 0; i < 4; i++) begin
      if (m_alm[i] < 128) begin
        int cv;
        en++;
        case (i)
          0: cv = cal_min; 1: cv = cal_hour; 2: cv = cal_date; default: cv = cal_wday;
        endcase
        if ((m_alm[i] % (lim[i] + 1)) != (cv % (lim[i] + 1))) return 0;
      end
    end
    return en > 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_alm[i] = 128;
      m_ie = 0; m_flag = 0; m_sf = 0;
    end else begin
      bit ev;
      ev = cal_step && cal_sec == 0 && m_hit();
      if (ev) m_flag = 1;
      else if (reg_wr && reg_addr == 1 && !reg_wdata[3]) m_flag = 0;
      if (cal_step) m_sf = 1;
      else if (reg_wr && reg_addr == 1 && !reg_wdata[4]) m_sf = 0;
      if (reg_wr && reg_addr == 0) m_ie = reg_wdata[1];
      for (int i = 0; i < 4; i++)
        if (reg_wr && reg_addr == 5'(10 + i)) m_alm[i] = reg_wdata;
    end
  end

  // per-clock comparison of the interrupt line (R7)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (alarm_irq_n !== !(m_flag && m_ie)) begin
        errors++;
        $display("FAIL R7 per-clock irq: actual %0b expected %0b", alarm_irq_n, !(m_flag && m_ie));
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic step(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                      input logic [7:0] d, input logic [7:0] w);
    @(negedge clk);
    cal_step = 1'b1; cal_sec = s; cal_min = mi; cal_hour = h; cal_date = d; cal_wday = w;
    @(negedge clk);
    cal_step = 1'b0;
  endtask

  task automatic irq_is(input logic exp, input string tag);
    @(negedge clk);
    #1 chk(tag, {7'd0, alarm_irq_n}, {7'd0, exp});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h0A, 8'h80, "R1 minute reset");
    rd(5'h0D, 8'h80, "R1 weekday reset");
    rd(5'h01, 8'h00, "R1 ctrl_b reset");
    rd(5'h00, 8'h00, "R1 ctrl_a reset");
    irq_is(1'b1, "R1 irq reset");
    // R2 map and readback
    wr(5'h0A, 8'h25); rd(5'h0A, 8'h25, "R2 minute readback");
    wr(5'h0C, 8'hB1); rd(5'h0C, 8'hB1, "R2 date readback");
    wr(5'h00, 8'hFF); rd(5'h00, 8'h02, "R2 ctrl_a only enable bit");
    rd(5'h05, 8'h00, "R2 unmapped reads zero");
    // R8 step flag
    step(8'h15, 8'h00, 8'h00, 8'h01, 8'h00);
    rd(5'h01, 8'h10, "R8 step flag set");
    wr(5'h01, 8'h10); rd(5'h01, 8'h10, "R8 write one keeps flag");
    wr(5'h01, 8'h00); rd(5'h01, 8'h00, "R8 write zero clears");
    // arm minute 30 only
    wr(5'h0A, 8'h30); wr(5'h0B, 8'h80); wr(5'h0C, 8'h80); wr(5'h0D, 8'h80);
    step(8'h00, 8'h29, 8'h10, 8'h04, 8'h02);
    rd(5'h01, 8'h10, "R9 minute mismatch no flag");
    step(8'h59, 8'h30, 8'h10, 8'h04, 8'h02);
    rd(5'h01, 8'h10, "R3 nonzero seconds no eval");
    step(8'h00, 8'h30, 8'h10, 8'h04, 8'h02);
    rd(5'h01, 8'h18, "R3 match sets flag");
    irq_is(1'b0, "R7 irq asserted");
    irq_is(1'b0, "R7 irq level held");
    wr(5'h01, 8'h08); rd(5'h01, 8'h08, "R6 write one keeps alarm flag");
    wr(5'h00, 8'h00); irq_is(1'b1, "R7 enable off releases irq");
    rd(5'h01, 8'h08, "R7 flag survives disable");
    wr(5'h00, 8'h02); irq_is(1'b0, "R7 enable on reasserts");
    wr(5'h01, 8'h00); rd(5'h01, 8'h00, "R6 write zero clears");
    irq_is(1'b1, "R6 irq released after clear");
    // R4 hour with stray bit 6, weekday disabled
    wr(5'h0A, 8'h80); wr(5'h0B, 8'h52); wr(5'h0D, 8'h85);
    step(8'h00, 8'h11, 8'h13, 8'h04, 8'h03);
    rd(5'h01, 8'h10, "R4 hour mismatch");
    step(8'h00, 8'h11, 8'h12, 8'h04, 8'h03);
    rd(5'h01, 8'h18, "R4 masked hour match, weekday ignored");
    wr(5'h01, 8'h00);
    wr(5'h0D, 8'h05);
    step(8'h00, 8'h11, 8'h12, 8'h04, 8'h03);
    rd(5'h01, 8'h10, "R4 enabled weekday mismatch");
    step(8'h00, 8'h11, 8'h12, 8'h04, 8'h0D);
    rd(5'h01, 8'h18, "R4 weekday masked to 3 bits matches");
    wr(5'h01, 8'h00);
    // date field
    wr(5'h0B, 8'h80); wr(5'h0D, 8'h80); wr(5'h0C, 8'h28);
    step(8'h00, 8'h00, 8'h00, 8'h27, 8'h00);
    rd(5'h01, 8'h10, "R9 date mismatch");
    step(8'h00, 8'h00, 8'h00, 8'h28, 8'h00);
    rd(5'h01, 8'h18, "R4 date match");
    wr(5'h01, 8'h00);
    // R5 all disabled
    wr(5'h0C, 8'h80);
    step(8'h00, 8'h00, 8'h00, 8'h28, 8'h00);
    rd(5'h01, 8'h10, "R5 all disabled never fires");
    // R6 set wins over same-cycle clear
    wr(5'h0A, 8'h45);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'h01; reg_wdata = 8'h00;
    cal_step = 1'b1; cal_sec = 8'h00; cal_min = 8'h45;
    @(negedge clk);
    reg_wr = 1'b0; cal_step = 1'b0;
    rd(5'h01, 8'h18, "R6 set wins over clear");
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule